// File: doc/BRIEF.md
# Trailing Bit Manipulation Unit

This block evaluates a set of single-operand bit tricks that locate the lowest clear bit or the lowest set bit of a word. Each trick combines the operand, its complement, and either the operand plus one or the operand minus one. The same block also pulls a bit field out of the operand. For that field extract, a 32-bit immediate packs the field's starting bit and its length. An execution pipeline hands over one operation per cycle: an operation code, the source word, the immediate, an operand-size bit and a 64-bit-mode flag.

Results are held in one output register stage with a valid/ready handshake. A zero flag travels with each result. The operand is 64 bits wide only when the size bit is set and the 64-bit-mode flag is also high. In every other case the unit works on the low 32 bits and clears the upper half of the result.

Top module: `tbm_unit`

## Requirements
- R1: Op codes 0, 1 and 2 return x & (x+1), x | (x+1) and x ^ (x+1) respectively, where x is the operand at the active width.
- R2: Op code 3 returns x | ~(x+1) and op code 4 returns ~x & (x+1).
- R3: Op codes 5, 6, 7 and 8 return x | (x-1), ~x | (x-1), ~x | (x+1) and ~x & (x-1) respectively.
- R4: Op code 9 returns (x >> s) & ((1 << n) - 1). Here s is imm_i[7:0] and n is imm_i[15:8]. Bits imm_i[31:16] do not change the result.
- R5: For op code 9, a start s at or above the active width gives zero. A length n at or above the active width keeps every bit from s upward. A length of zero gives zero.
- R6: The width is 64 bits only when long_mode_i=1 and wide_i=1. Otherwise src_i[63:32] has no effect, all arithmetic is done on 32 bits, and result_o[63:32] is zero.
- R7: zero_o is 1 exactly when the result_o it accompanies is all zeros.
- R8: An input is taken on a rising edge when in_valid_i and in_ready_o are both high. Its result appears with out_valid_o=1 after that edge. in_ready_o is high whenever the output stage is empty or out_ready_i is high, so one operation per cycle is sustained.
- R9: While out_valid_o=1 and out_ready_i=0, in_ready_o is low and result_o and zero_o stay unchanged, whatever the inputs do.
- R10: Op codes 10 to 15 return zero with zero_o=1.
- R11: During and directly after reset, out_valid_o is 0 and in_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Operation can be taken this cycle |
| op_i | input | 4 | Operation code (0 to 9 defined) |
| src_i | input | 64 | Source operand |
| imm_i | input | 32 | Field immediate: [7:0] start, [15:8] length |
| wide_i | input | 1 | Operand-size bit, 1 = 64-bit |
| long_mode_i | input | 1 | 64-bit mode flag; when low the size bit is ignored |
| out_valid_o | output | 1 | Result held |
| out_ready_i | input | 1 | Downstream takes the result |
| result_o | output | 64 | Registered result |
| zero_o | output | 1 | Result is zero |

## Verification
The bit-trick ops are driven with an odd operand ending in 0111 and with an even operand ending in 0000. This separates the plus-one forms, which act on the trailing ones, from the minus-one forms, which act on the trailing zeros, and it also produces a zero result. All-ones and 0x00000000FFFFFFFF operands are run in the wide, narrow and size-ignored settings, where a carry out of bit 31 shows up only if the width is chosen wrongly. The field extract is tried with junk in the upper immediate bits, with starts and lengths just inside and beyond both widths, and with a zero length. Stall and back-to-back sequences show whether results are held or overwritten.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
  localparam int XLEN  = 64;
  localparam int IMM_W = 32;
  localparam int POS_W = 8;
  localparam int OP_W  = 4;

  typedef enum logic [OP_W-1:0] {
    OP_FILL_LC   = 4'd0,
    OP_SET_LC    = 4'd1,
    OP_MASK_LC   = 4'd2,
    OP_ISO_LC    = 4'd3,
    OP_ISO_LC_N  = 4'd4,
    OP_FILL_LS   = 4'd5,
    OP_ISO_LS_N  = 4'd6,
    OP_INV_TONES = 4'd7,
    OP_MASK_TZ   = 4'd8,
    OP_FIELD     = 4'd9
  } tbm_op_e;
endpackage

// File: rtl/tbm_bitops.sv
module tbm_bitops
  import tbm_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    x_i,
  output logic [W-1:0]    res_o,
  output logic            hit_o
);
  logic [W-1:0] inc, dec;
  assign inc = x_i + W'(1);
  assign dec = x_i - W'(1);

  always_comb begin
    hit_o = 1'b1;
    case (op_i)
      OP_FILL_LC:   res_o = x_i & inc;
      OP_SET_LC:    res_o = x_i | inc;
      OP_MASK_LC:   res_o = x_i ^ inc;
      OP_ISO_LC:    res_o = x_i | ~inc;
      OP_ISO_LC_N:  res_o = ~x_i & inc;
      OP_FILL_LS:   res_o = x_i | dec;
      OP_ISO_LS_N:  res_o = ~x_i | dec;
      OP_INV_TONES: res_o = ~x_i | inc;
      OP_MASK_TZ:   res_o = ~x_i & dec;
      default: begin
        res_o = '0;
        hit_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/tbm_field.sv
module tbm_field
  import tbm_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0]     x_i,
  input  logic [POS_W-1:0] start_i,
  input  logic [POS_W-1:0] len_i,
  output logic [W-1:0]     res_o
);
  localparam int SW = $clog2(W);

  logic start_oob, len_full;
  logic [W-1:0] shifted, mask;

  assign start_oob = {{(32-POS_W){1'b0}}, start_i} >= 32'(W);
  assign len_full  = {{(32-POS_W){1'b0}}, len_i} >= 32'(W);

  // Both shift amounts are below W here, so the low SW bits suffice.
  assign shifted = x_i >> start_i[SW-1:0];
  assign mask    = len_full ? '1 : ~({W{1'b1}} << len_i[SW-1:0]);
  assign res_o   = start_oob ? '0 : (shifted & mask);

  logic unused_hi;
  assign unused_hi = ^{start_i[POS_W-1:SW], len_i[POS_W-1:SW]};
endmodule

// File: rtl/tbm_hold.sv
module tbm_hold #(
  parameter int DW = 65
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          drop_i,
  input  logic [DW-1:0] data_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      if (load_i) begin
        valid_o <= 1'b1;
        data_o  <= data_i;
      end else if (drop_i) begin
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tbm_unit.sv
module tbm_unit
  import tbm_pkg::*;
#(
  parameter int XW = XLEN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [OP_W-1:0]  op_i,
  input  logic [XW-1:0]    src_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             wide_i,
  input  logic             long_mode_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [XW-1:0]    result_o,
  output logic             zero_o
);
  localparam int NLANE = 2;
  localparam int DW    = XW + 1;

  logic [POS_W-1:0] fld_start, fld_len;
  assign fld_start = imm_i[POS_W-1:0];
  assign fld_len   = imm_i[2*POS_W-1:POS_W];

  logic unused_imm;
  assign unused_imm = ^imm_i[IMM_W-1:2*POS_W];

  logic is_field, wide_eff;
  assign is_field = (op_i == OP_FIELD);
  assign wide_eff = long_mode_i & wide_i;

  logic [XW-1:0] lane_res [NLANE];

  // Lane 0 is the narrow (half) width, lane 1 the full width.
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int W = (XW / 2) << g;
    logic [W-1:0] bit_res, fld_res;
    logic         bit_hit;

    tbm_bitops #(.W(W)) u_bitops (
      .op_i  (op_i),
      .x_i   (src_i[W-1:0]),
      .res_o (bit_res),
      .hit_o (bit_hit)
    );

    tbm_field #(.W(W)) u_field (
      .x_i     (src_i[W-1:0]),
      .start_i (fld_start),
      .len_i   (fld_len),
      .res_o   (fld_res)
    );

    assign lane_res[g] = is_field ? XW'(fld_res) : (bit_hit ? XW'(bit_res) : '0);
  end

  logic [XW-1:0] next_res;
  logic          accept;
  logic [DW-1:0] held;

  assign next_res   = lane_res[wide_eff];
  assign in_ready_o = ~out_valid_o | out_ready_i;
  assign accept     = in_valid_i & in_ready_o;

  tbm_hold #(.DW(DW)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .drop_i  (out_ready_i),
    .data_i  ({next_res == '0, next_res}),
    .valid_o (out_valid_o),
    .data_o  (held)
  );

  assign result_o = held[XW-1:0];
  assign zero_o   = held[XW];
endmodule

// File: rtl/tbm_unit_chk.sv
module tbm_unit_chk #(
  parameter int XW = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic [3:0]    op_i,
  input logic          wide_i,
  input logic          long_mode_i,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [XW-1:0] result_o,
  input logic          zero_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r11_idle_in_reset: assert (!out_valid_o && in_ready_o);
    end
  end

  a_r8_accept_gives_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);

  a_r9_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(result_o) && $stable(zero_o));

  a_r9_stall_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  a_r7_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (zero_o == (result_o == '0)));

  a_r6_upper_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && !(long_mode_i && wide_i) |=> result_o[XW-1:XW/2] == '0);

  a_r10_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && (op_i > 4'd9) |=> (result_o == '0) && zero_o);
endmodule

bind tbm_unit tbm_unit_chk #(.XW(XW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .op_i        (op_i),
  .wide_i      (wide_i),
  .long_mode_i (long_mode_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .result_o    (result_o),
  .zero_o      (zero_o)
);

// File: tb/tbm_unit_tb_top.sv
module tbm_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  op = '0;
  logic [63:0] src = '0;
  logic [31:0] imm = '0;
  logic        wide = 1'b0;
  logic        lmode = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] result;
  logic        zero;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  tbm_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .op_i(op), .src_i(src), .imm_i(imm), .wide_i(wide), .long_mode_i(lmode),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .result_o(result), .zero_o(zero)
  );

  // {op, long_mode, wide, src, imm, expected}
  localparam int NV = 30;
  localparam logic [165:0] VECS [NV] = '{
    {4'd0, 1'b1, 1'b1, 64'h00000000000000A7, 32'h0, 64'h00000000000000A0},
    {4'd1, 1'b1, 1'b1, 64'h00000000000000A7, 32'h0, 64'h00000000000000AF},
    {4'd2, 1'b1, 1'b1, 64'h00000000000000A7, 32'h0, 64'h000000000000000F},
    {4'd3, 1'b1, 1'b1, 64'h00000000000000A7, 32'h0, 64'hFFFFFFFFFFFFFFF7},
    {4'd4, 1'b1, 1'b1, 64'h00000000000000A7, 32'h0, 64'h0000000000000008},
    {4'd5, 1'b1, 1'b1, 64'h00000000000000A7, 32'h0, 64'h00000000000000A7},
    {4'd6, 1'b1, 1'b1, 64'h00000000000000A7, 32'h0, 64'hFFFFFFFFFFFFFFFE},
    {4'd7, 1'b1, 1'b1, 64'h00000000000000A7, 32'h0, 64'hFFFFFFFFFFFFFFF8},
    {4'd8, 1'b1, 1'b1, 64'h00000000000000A7, 32'h0, 64'h0000000000000000},
    {4'd8, 1'b1, 1'b1, 64'h0000000000000050, 32'h0, 64'h000000000000000F},
    {4'd5, 1'b1, 1'b1, 64'h0000000000000050, 32'h0, 64'h000000000000005F},
    {4'd6, 1'b1, 1'b1, 64'h0000000000000050, 32'h0, 64'hFFFFFFFFFFFFFFEF},
    {4'd3, 1'b1, 1'b0, 64'hFFFFFFFFFFFFFFFF, 32'h0, 64'h00000000FFFFFFFF},
    {4'd3, 1'b1, 1'b1, 64'hFFFFFFFFFFFFFFFF, 32'h0, 64'hFFFFFFFFFFFFFFFF},
    {4'd3, 1'b0, 1'b1, 64'h00000000FFFFFFFF, 32'h0, 64'h00000000FFFFFFFF},
    {4'd3, 1'b1, 1'b1, 64'h00000000FFFFFFFF, 32'h0, 64'hFFFFFFFEFFFFFFFF},
    {4'd0, 1'b1, 1'b0, 64'h12345678000000FF, 32'h0, 64'h0000000000000000},
    {4'd1, 1'b0, 1'b0, 64'hDEADBEEF7FFFFFFF, 32'h0, 64'h00000000FFFFFFFF},
    {4'd9, 1'b1, 1'b1, 64'hFEDCBA9876543210, 32'h00001008, 64'h0000000000005432},
    {4'd9, 1'b1, 1'b1, 64'hFEDCBA9876543210, 32'hABCD1008, 64'h0000000000005432},
    {4'd9, 1'b1, 1'b1, 64'hFEDCBA9876543210, 32'h0000103C, 64'h000000000000000F},
    {4'd9, 1'b1, 1'b1, 64'hFEDCBA9876543210, 32'h00000840, 64'h0000000000000000},
    {4'd9, 1'b1, 1'b1, 64'hFEDCBA9876543210, 32'h00004004, 64'h0FEDCBA987654321},
    {4'd9, 1'b1, 1'b1, 64'hFEDCBA9876543210, 32'h0000C800, 64'hFEDCBA9876543210},
    {4'd9, 1'b1, 1'b1, 64'hFEDCBA9876543210, 32'h00000004, 64'h0000000000000000},
    {4'd9, 1'b1, 1'b0, 64'hFEDCBA9876543210, 32'h00002010, 64'h0000000000007654},
    {4'd9, 1'b1, 1'b0, 64'hFEDCBA9876543210, 32'h00000820, 64'h0000000000000000},
    {4'd9, 1'b1, 1'b0, 64'hFEDCBA9876543210, 32'h00004008, 64'h0000000000765432},
    {4'd10, 1'b1, 1'b1, 64'h00000000000000A7, 32'h0, 64'h0000000000000000},
    {4'd15, 1'b1, 1'b1, 64'h00000000000000A7, 32'h0, 64'h0000000000000000}
  };

  string tag_tbl [NV] = '{
    "R1", "R1", "R1", "R2", "R2", "R3", "R3", "R3", "R3", "R3", "R3", "R3",
    "R6", "R6", "R6", "R6", "R6", "R6",
    "R4", "R4", "R5", "R5", "R5", "R5", "R5", "R6", "R6", "R5",
    "R10", "R10"
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic drive(input logic [3:0] o, input logic l, input logic w,
                       input logic [63:0] s, input logic [31:0] i);
    op = o; lmode = l; wide = w; src = s; imm = i; in_valid = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    check("R11", {63'd0, out_valid}, 64'd0);
    check("R11", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", {63'd0, out_valid}, 64'd0);

    // Vector table
    for (int k = 0; k < NV; k++) begin
      drive(VECS[k][165:162], VECS[k][161], VECS[k][160], VECS[k][159:96], VECS[k][95:64]);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check(tag_tbl[k], result, VECS[k][63:0]);
      check("R8", {63'd0, out_valid}, 64'd1);
      check("R7", {63'd0, zero}, {63'd0, VECS[k][63:0] == 64'd0});
    end

    // R8: output drains when nothing new is taken
    @(negedge clk);
    check("R8", {63'd0, out_valid}, 64'd0);

    // R9: stall holds the result and blocks input
    out_ready = 1'b0;
    drive(4'd2, 1'b1, 1'b1, 64'hA7, 32'h0);
    @(posedge clk);
    @(negedge clk);
    drive(4'd1, 1'b1, 1'b1, 64'hA7, 32'h0);
    for (int c = 0; c < 3; c++) begin
      check("R9", {63'd0, in_ready}, 64'd0);
      check("R9", result, 64'h0F);
      check("R9", {63'd0, out_valid}, 64'd1);
      @(negedge clk);
    end
    check("R9", result, 64'h0F);
    // R8: release; pending input is taken in the same cycle
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", result, 64'hAF);
    check("R8", {63'd0, out_valid}, 64'd1);

    // R8: back-to-back, one result per cycle
    drive(4'd0, 1'b1, 1'b1, 64'hA7, 32'h0);
    @(posedge clk);
    @(negedge clk);
    check("R8", result, 64'hA0);
    drive(4'd7, 1'b1, 1'b1, 64'hA7, 32'h0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", result, 64'hFFFFFFFFFFFFFFF8);
    check("R7", {63'd0, zero}, 64'd0);

    // R11: reset in mid-run clears the output stage
    drive(4'd1, 1'b1, 1'b1, 64'h1, 32'h0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R11", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", {63'd0, in_ready}, 64'd1);

    finish_run();
  end
endmodule